// File: doc/BRIEF.md
# Conversion Sequencer for a Two-Channel Sampling Converter

This block is the digital control core of a two-channel successive-approximation converter. It runs entirely on the conversion clock. It holds a configuration word and a manually chosen channel, and it accepts an asynchronous active-low start input and a read strobe. From these it decides when the sampler leaves acquisition and enters hold, which channel each conversion uses, and what a programmable status pin shows. The analog core is modelled as a fixed-length conversion window. Sampling, bit decisions and the serial shift interface lie outside the block.

Conversions are started either by a falling edge on the start input (manual trigger) or by the block itself three clocks after the previous conversion ends (auto trigger). The channel comes either from the last channel write (manual selection) or from an internal pointer that alternates the two channels (auto selection). The status pin works either as an end-of-conversion level or as a sticky interrupt that a read clears, and its polarity is programmable. Each finished conversion gives a one-cycle result-valid pulse together with the channel that produced it.

Top module: `adc_conv_seq`

## Requirements
- R1: A conversion keeps `sh_hold` high for exactly 18 consecutive cycles. `done_pulse` is high for the one cycle that follows the last hold cycle.
- R2: With configuration bit 9 = 1 (manual trigger), a falling edge on `start_n` raises `sh_hold` at the third rising clock edge after the first edge that samples `start_n` low (two synchronizer stages, then one start register).
- R3: A manual start whose acceptance edge falls inside a running conversion, or less than 21 cycles after the previous start, is ignored.
- R4: With configuration bit 9 = 0 (auto trigger), a new conversion begins 3 cycles after `sh_hold` falls, so starts are 21 cycles apart. After bit 9 returns to 1, no further conversion starts by itself.
- R5: With configuration bit 11 = 0, each conversion uses the channel last written through `cmd_wr`/`cmd_chan`. `chan_sel` holds that value for the whole conversion.
- R6: With configuration bit 11 = 1, conversions alternate between channel 0 and channel 1, and the first conversion after the configuration write uses channel 0. After a write that clears bit 11, the next conversion uses the manual channel.
- R7: Configuration bit 6 = 1 selects end-of-conversion mode, in which the status pin is active exactly while `sh_hold` is high. Bit 7 = 1 makes the pin active low and bit 7 = 0 makes it active high.
- R8: Configuration bit 6 = 0 selects interrupt mode. The pin becomes active on the edge that ends a conversion and stays active until the edge that samples `rd_strobe` high clears it. A configuration write also clears it.
- R9: During a `done_pulse`, `done_chan` equals the channel of the conversion that just ended.
- R10: After reset the configuration is 12'hAC0 (auto channel, manual trigger, active-low end-of-conversion). `sh_hold`, `done_pulse` and `chan_sel` are 0, and `status_pin` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 12 | Configuration word (bit 11 auto channel, bit 9 manual trigger, bit 7 active low, bit 6 end-of-conversion mode) |
| cmd_wr | input | 1 | Manual channel write strobe |
| cmd_chan | input | 1 | Manual channel number |
| start_n | input | 1 | Asynchronous conversion start, acts on its falling edge |
| rd_strobe | input | 1 | Result read, clears the interrupt |
| sh_hold | output | 1 | Sample/hold control; high while converting |
| chan_sel | output | 1 | Channel of the current or last conversion |
| status_pin | output | 1 | Programmable end-of-conversion / interrupt pin |
| done_pulse | output | 1 | One-cycle result-valid pulse |
| done_chan | output | 1 | Channel tag of the last finished conversion |

## Verification
A manual start is due on `sh_hold` three clock edges after the edge that first samples `start_n` low. The bench drives on falling clock edges and checks exactly three falling edges later. It then counts 18 high samples and expects `done_pulse`, the channel tag and the end-of-conversion level on the first low sample. In auto trigger the bench measures the high and low run lengths sample by sample (expecting 18 and 3), rather than waiting a fixed time. In interrupt mode it checks the pin on the first low-hold sample and again one edge after a one-cycle read strobe. The ignored-start cases place falling edges so that acceptance would land inside the conversion and 19 cycles after the previous start. The bench then checks that `sh_hold` stays low for ten further cycles.

// File: rtl/adc_seq_pkg.sv
// Package: shared configuration layout and decoded configuration type for
// the conversion sequencer. Assumes a 12-bit configuration word.
package adc_seq_pkg;
    localparam int CFG_W          = 12;
    localparam int BIT_AUTO_CHAN  = 11;
    localparam int BIT_MAN_TRIG   = 9;
    localparam int BIT_ACT_LOW    = 7;
    localparam int BIT_FUNC       = 6;

    typedef enum logic {
        STAT_INT = 1'b0,
        STAT_EOC = 1'b1
    } stat_fn_t;

    typedef struct packed {
        logic     auto_chan;
        logic     manual_trig;
        logic     active_low;
        stat_fn_t func;
    } seq_cfg_t;

    // Pull the fields the sequencer uses out of a raw configuration word.
    function automatic seq_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        seq_cfg_t c;
        c.auto_chan   = w[BIT_AUTO_CHAN];
        c.manual_trig = w[BIT_MAN_TRIG];
        c.active_low  = w[BIT_ACT_LOW];
        c.func        = stat_fn_t'(w[BIT_FUNC]);
        return c;
    endfunction
endpackage

// File: rtl/adc_start_sync.sv
// Module: brings the asynchronous active-low start input into the clock
// domain through a flop chain and flags its falling edge for one cycle.
// Assumes STAGES >= 2. The chain resets to the idle (high) level.
module adc_start_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    output logic fall_seen
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= start_n;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        // Each further stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
        end
    end

    // Previous synchronized level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain[STAGES-1];
    end

    // A high-to-low step of the synchronized level.
    always_comb fall_seen = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/adc_conv_timer.sv
// Module: conversion window and start spacing. A start loads an
// 18-cycle conversion count and a 21-cycle spacing count. Starts come from
// the synchronized edge (manual) or from the spacing count running out (auto).
// Assumes ACQ_CLKS >= 1, so a busy conversion always has spacing left.
module adc_conv_timer #(
    parameter int CONV_CLKS = 18,
    parameter int ACQ_CLKS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_seen,
    input  logic auto_trig,
    output logic busy,
    output logic start_go,
    output logic ending,
    output logic done_pulse
);
    localparam int CYCLE_CLKS = CONV_CLKS + ACQ_CLKS;
    localparam int CNT_W      = $clog2(CYCLE_CLKS + 1);
    localparam logic [CNT_W-1:0] CONV_LOAD  = CNT_W'(CONV_CLKS - 1);
    localparam logic [CNT_W-1:0] SPACE_LOAD = CNT_W'(CYCLE_CLKS - 1);

    logic [CNT_W-1:0] conv_cnt;
    logic [CNT_W-1:0] space_cnt;
    logic             space_done;

    // Start is allowed only once the minimum spacing has elapsed.
    always_comb begin
        space_done = (space_cnt == '0);
        start_go   = space_done & (auto_trig | fall_seen);
        ending     = busy & (conv_cnt == '0);
    end

    // Conversion window counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            conv_cnt <= '0;
        end else if (start_go) begin
            busy     <= 1'b1;
            conv_cnt <= CONV_LOAD;
        end else if (ending) begin
            busy     <= 1'b0;
        end else if (busy) begin
            conv_cnt <= conv_cnt - 1'b1;
        end
    end

    // Spacing counter measured from each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)          space_cnt <= '0;
        else if (start_go)   space_cnt <= SPACE_LOAD;
        else if (!space_done) space_cnt <= space_cnt - 1'b1;
    end

    // One-cycle result-valid pulse after the last conversion cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) done_pulse <= 1'b0;
        else        done_pulse <= ending;
    end
endmodule

// File: rtl/adc_chan_picker.sv
// Module: chooses the channel of each conversion. In manual selection it
// uses the last command write. In auto selection it uses a pointer that
// restarts at channel 0 on any configuration write that enables auto mode.
// It also latches the channel tag that goes with the result-valid pulse.
module adc_chan_picker #(
    parameter int NUM_CHANS = 2,
    parameter int CHAN_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              wr_auto_chan,
    input  logic              auto_mode,
    input  logic              cmd_wr,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic              start_go,
    input  logic              ending,
    output logic [CHAN_W-1:0] conv_chan,
    output logic [CHAN_W-1:0] done_chan
);
    localparam logic [CHAN_W-1:0] LAST_CHAN = CHAN_W'(NUM_CHANS - 1);

    logic [CHAN_W-1:0] man_chan;
    logic [CHAN_W-1:0] auto_ptr;

    // Manual channel register written by the command path.
    always_ff @(posedge clk) begin
        if (!rst_n)      man_chan <= '0;
        else if (cmd_wr) man_chan <= cmd_chan;
    end

    // Auto pointer: restart on enabling write, advance per auto start.
    always_ff @(posedge clk) begin
        if (!rst_n)                       auto_ptr <= '0;
        else if (cfg_wr && wr_auto_chan)  auto_ptr <= '0;
        else if (start_go && auto_mode)   auto_ptr <= (auto_ptr == LAST_CHAN) ? '0 : auto_ptr + 1'b1;
    end

    // Channel latched for the conversion being started.
    always_ff @(posedge clk) begin
        if (!rst_n)        conv_chan <= '0;
        else if (start_go) conv_chan <= auto_mode ? auto_ptr : man_chan;
    end

    // Tag captured with the result as the conversion ends.
    always_ff @(posedge clk) begin
        if (!rst_n)      done_chan <= '0;
        else if (ending) done_chan <= conv_chan;
    end
endmodule

// File: rtl/adc_status_pin.sv
// Module: programmable status pin. End-of-conversion mode follows the
// busy level. Interrupt mode sets a flag as a conversion ends and clears it
// on a read or a configuration write. Polarity is applied last.
module adc_status_pin
    import adc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     busy,
    input  logic     ending,
    input  logic     rd_strobe,
    input  logic     cfg_wr,
    input  stat_fn_t func,
    input  logic     active_low,
    output logic     pin
);
    logic int_flag;
    logic active;

    // Sticky interrupt flag; end of conversion beats a same-cycle read.
    always_ff @(posedge clk) begin
        if (!rst_n)                         int_flag <= 1'b0;
        else if (cfg_wr)                    int_flag <= 1'b0;
        else if (ending && func == STAT_INT) int_flag <= 1'b1;
        else if (rd_strobe)                 int_flag <= 1'b0;
    end

    // Select the function, then apply polarity.
    always_comb begin
        active = (func == STAT_EOC) ? busy : int_flag;
        pin    = active ^ active_low;
    end
endmodule

// File: rtl/adc_conv_seq.sv
// Module: top of the conversion sequencer. Holds the configuration word
// and ties together start synchronization, conversion timing, channel
// choice and the status pin. Every input except start_n is synchronous to clk.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int                 CONV_CLKS   = 18,
    parameter int                 ACQ_CLKS    = 3,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 NUM_CHANS   = 2,
    parameter int                 CHAN_W      = $clog2(NUM_CHANS),
    parameter logic [CFG_W-1:0]   CFG_RESET   = 12'hAC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              cmd_wr,
    input  logic [CHAN_W-1:0] cmd_chan,
    input  logic              start_n,
    input  logic              rd_strobe,
    output logic              sh_hold,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              status_pin,
    output logic              done_pulse,
    output logic [CHAN_W-1:0] done_chan
);
    logic [CFG_W-1:0] cfg_q;
    seq_cfg_t         cfg;
    seq_cfg_t         cfg_in;
    logic             fall_seen;
    logic             busy;
    logic             start_go;
    logic             ending;

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= cfg_data;
    end

    // Decoded views of the stored and incoming configuration.
    always_comb begin
        cfg    = decode_cfg(cfg_q);
        cfg_in = decode_cfg(cfg_data);
    end

    adc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n   (start_n),
        .fall_seen (fall_seen)
    );

    adc_conv_timer #(.CONV_CLKS(CONV_CLKS), .ACQ_CLKS(ACQ_CLKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_seen  (fall_seen),
        .auto_trig  (~cfg.manual_trig),
        .busy       (busy),
        .start_go   (start_go),
        .ending     (ending),
        .done_pulse (done_pulse)
    );

    adc_chan_picker #(.NUM_CHANS(NUM_CHANS), .CHAN_W(CHAN_W)) u_chan (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .wr_auto_chan (cfg_in.auto_chan),
        .auto_mode    (cfg.auto_chan),
        .cmd_wr       (cmd_wr),
        .cmd_chan     (cmd_chan),
        .start_go     (start_go),
        .ending       (ending),
        .conv_chan    (chan_sel),
        .done_chan    (done_chan)
    );

    adc_status_pin u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .ending     (ending),
        .rd_strobe  (rd_strobe),
        .cfg_wr     (cfg_wr),
        .func       (cfg.func),
        .active_low (cfg.active_low),
        .pin        (status_pin)
    );

    always_comb sh_hold = busy;
endmodule

// File: rtl/adc_conv_seq_chk.sv
// Checker: timing and status properties of the conversion sequencer,
// attached to every instance of the top module by the bind below.
module adc_conv_seq_chk #(
    parameter int CONV_CLKS = 18,
    parameter int ACQ_CLKS  = 3,
    parameter int CHAN_W    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              done_pulse,
    input logic [CHAN_W-1:0] chan_sel,
    input logic [CHAN_W-1:0] done_chan,
    input logic              status_pin,
    input logic              eoc_mode,
    input logic              act_low,
    input logic              rd_strobe,
    input logic              cfg_wr,
    input logic              ending
);
    localparam int CYCLE_CLKS = CONV_CLKS + ACQ_CLKS;
    localparam int RUN_W      = $clog2(CYCLE_CLKS + 1) + 1;

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] since_q;
    logic             hold_d;
    logic             rise;

    always_comb rise = hold & ~hold_d;

    // Length of the current high run of the hold output.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (hold) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // Cycles since the last conversion start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_d  <= 1'b0;
            since_q <= '1;
        end else begin
            hold_d  <= hold;
            if (rise)              since_q <= '0;
            else if (since_q != '1) since_q <= since_q + 1'b1;
        end
    end

    // R1
    hold_run_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> (run_q < RUN_W'(CONV_CLKS)));

    // R1
    hold_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && run_q != '0) |-> (run_q == RUN_W'(CONV_CLKS)));

    // R1
    done_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (!hold && $past(hold)));

    // R3
    start_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (since_q >= RUN_W'(CYCLE_CLKS - 1)));

    // R7
    eoc_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_mode |-> (status_pin == (hold ^ act_low)));

    // R8
    int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eoc_mode && rd_strobe && !ending && !cfg_wr) |=> (status_pin == act_low));

    // R9
    done_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (done_chan == $past(chan_sel)));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(
    .CONV_CLKS (CONV_CLKS),
    .ACQ_CLKS  (ACQ_CLKS),
    .CHAN_W    (CHAN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (sh_hold),
    .done_pulse (done_pulse),
    .chan_sel   (chan_sel),
    .done_chan  (done_chan),
    .status_pin (status_pin),
    .eoc_mode   (cfg.func == adc_seq_pkg::STAT_EOC),
    .act_low    (cfg.active_low),
    .rd_strobe  (rd_strobe),
    .cfg_wr     (cfg_wr),
    .ending     (ending)
);

// File: tb/adc_conv_seq_bench.sv
// Bench: directed scenarios, one task each. Inputs change on falling
// edges and outputs are sampled there as well.
module adc_conv_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [11:0] cfg_data = '0;
    logic        cmd_wr = 1'b0;
    logic [0:0]  cmd_chan = '0;
    logic        start_n = 1'b1;
    logic        rd_strobe = 1'b0;
    logic        sh_hold;
    logic [0:0]  chan_sel;
    logic        status_pin;
    logic        done_pulse;
    logic [0:0]  done_chan;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    adc_conv_seq u_adc_conv_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_data   (cfg_data),
        .cmd_wr     (cmd_wr),
        .cmd_chan   (cmd_chan),
        .start_n    (start_n),
        .rd_strobe  (rd_strobe),
        .sh_hold    (sh_hold),
        .chan_sel   (chan_sel),
        .status_pin (status_pin),
        .done_pulse (done_pulse),
        .done_chan  (done_chan)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [11:0] w);
        cfg_wr = 1'b1; cfg_data = w;
        tick(1);
        cfg_wr = 1'b0;
    endtask

    task automatic write_chan(input logic c);
        cmd_wr = 1'b1; cmd_chan = c;
        tick(1);
        cmd_wr = 1'b0;
    endtask

    // Falls start_n and checks hold three edges later (R2).
    task automatic fire(input string req);
        start_n = 1'b0;
        tick(3);
        check(req, sh_hold, 1);
        start_n = 1'b1;
    endtask

    // Waits until hold reaches the level; a timeout counts as a failure.
    task automatic wait_hold(input logic lvl, input string req);
        int n = 0;
        while (sh_hold != lvl && n < 60) begin
            tick(1);
            n++;
        end
        check({req, " wait"}, sh_hold, lvl);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R10 hold", sh_hold, 0);
        check("R10 status", status_pin, 1);
        check("R10 done", done_pulse, 0);
        check("R10 chan", chan_sel, 0);
        tick(1);
        check("R10 idle stays", sh_hold, 0);
    endtask

    task automatic t_manual;
        write_cfg(12'h2C0);
        write_chan(1'b1);
        tick(2);
        check("R2 before start", sh_hold, 0);
        fire("R2 rise after three edges");
        check("R7 eoc active low", status_pin, 0);
        check("R5 manual chan 1", chan_sel, 1);
        tick(17);
        check("R1 still holding at 18", sh_hold, 1);
        tick(1);
        check("R1 hold drops", sh_hold, 0);
        check("R1 done pulse", done_pulse, 1);
        check("R9 done chan 1", done_chan, 1);
        check("R7 eoc released", status_pin, 1);
        tick(1);
        check("R1 done one cycle", done_pulse, 0);
        write_chan(1'b0);
        tick(3);
        fire("R2 second start");
        check("R5 manual chan 0", chan_sel, 0);
        tick(18);
        check("R9 done chan 0", done_chan, 0);
        tick(25);
    endtask

    task automatic t_spacing;
        int highs = 0;
        fire("R3 first start");
        tick(7);
        start_n = 1'b0;
        tick(3);
        start_n = 1'b1;
        tick(6);
        start_n = 1'b0;
        tick(1);
        check("R3 conversion unaffected", sh_hold, 1);
        tick(1);
        check("R3 ends on time", sh_hold, 0);
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (sh_hold) highs++;
        end
        check("R3 early starts ignored", highs, 0);
        start_n = 1'b1;
        tick(5);
        fire("R3 later start accepted");
        tick(45);
    endtask

    task automatic t_int;
        write_cfg(12'h280);
        check("R8 idle inactive low", status_pin, 1);
        tick(2);
        fire("R8 start");
        check("R8 not yet active", status_pin, 1);
        tick(18);
        check("R8 hold ended", sh_hold, 0);
        check("R8 asserted at end", status_pin, 0);
        tick(4);
        check("R8 sticky", status_pin, 0);
        rd_strobe = 1'b1;
        tick(1);
        rd_strobe = 1'b0;
        check("R8 cleared by read", status_pin, 1);
        write_cfg(12'h200);
        check("R7 active high idle", status_pin, 0);
        tick(25);
        fire("R8 high start");
        tick(18);
        check("R8 active high set", status_pin, 1);
        rd_strobe = 1'b1;
        tick(1);
        rd_strobe = 1'b0;
        check("R8 active high cleared", status_pin, 0);
        tick(25);
    endtask

    task automatic t_eoc_high;
        write_cfg(12'h240);
        check("R7 high polarity idle", status_pin, 0);
        tick(2);
        fire("R7 start");
        check("R7 high polarity active", status_pin, 1);
        tick(18);
        check("R7 high polarity released", status_pin, 0);
        tick(25);
    endtask

    task automatic t_auto;
        int n;
        int none;
        write_chan(1'b1);
        write_cfg(12'h8C0);
        for (int k = 0; k < 4; k++) begin
            wait_hold(1'b1, "R4");
            check("R6 alternation", chan_sel, k % 2);
            check("R7 eoc in auto", status_pin, 0);
            n = 0;
            while (sh_hold && n < 40) begin tick(1); n++; end
            check("R1 auto length", n, 18);
            check("R9 auto tag", done_chan, k % 2);
            check("R7 gap released", status_pin, 1);
            n = 0;
            while (!sh_hold && n < 40) begin tick(1); n++; end
            check("R4 gap of three", n, 3);
        end
        write_cfg(12'h0C0);
        wait_hold(1'b0, "R6");
        wait_hold(1'b1, "R6");
        check("R6 back to manual", chan_sel, 1);
        write_cfg(12'h2C0);
        wait_hold(1'b0, "R4");
        none = 0;
        for (int i = 0; i < 30; i++) begin
            tick(1);
            if (sh_hold) none++;
        end
        check("R4 stops after manual", none, 0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_manual();
        t_spacing();
        t_int();
        t_eoc_high();
        t_auto();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule